// File: doc/BRIEF.md
# Iterative Fixed-Point Cube Root Unit

This unit takes an unsigned 8-bit operand and returns its cube root to two decimal places. On an accepted start pulse it multiplies the operand by one million, so the integer part of the root of the scaled value carries two fractional decimal digits. It then runs a bitwise restoring cube root, one result bit per clock.

After the root is built, the unit splits it into three decimal digits: one integer digit and two fractional digits. It does this by repeatedly subtracting hundreds and then tens, with no divider. The raw root and the digits are registered. They stay unchanged until the next operation completes, which is marked by a single-cycle done pulse.

Typical use: the caller waits until busy is low, pulses start with the operand, and reads the results in the cycle where done is high.

Top module: `cube_root_unit`

## Requirements
- R1: While the synchronous active-low reset is asserted, busy, done, root and all three digits are cleared to zero on the clock edge.
- R2: A start seen at a clock edge while busy is low captures the operand at that edge, and busy is high from that edge on.
- R3: For every operand n from 0 to 255, root is the largest integer y with y*y*y <= n*1000000. The largest possible root is 634.
- R4: The digits are binary-coded decimal, 4 bits each: dig_int = root/100, dig_f1 = (root mod 100)/10, dig_f2 = root mod 10. dig_int never exceeds 6, and the other two digits never exceed 9.
- R5: done is high for exactly one cycle per operation, and busy falls in that same cycle. With h = dig_int and t = dig_f1, done rises exactly 13+h+t clock edges after the edge that accepted start.
- R6: A start pulse while busy is high is ignored. The running operation keeps its operand and its timing.
- R7: root and the digits keep their values between completions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin an operation when idle |
| operand | input | 8 | Unsigned value to take the root of |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse when results are valid |
| root | output | 10 | Cube root of operand*10^6 |
| dig_int | output | 4 | Integer digit |
| dig_f1 | output | 4 | First fractional digit |
| dig_f2 | output | 4 | Second fractional digit |

## Verification
The embedded assertions check, on every cycle:
- done is a single-cycle pulse, and busy is low while done is high;
- an idle start makes the unit busy;
- the results stay still except at a completion;
- at completion, the digits are in range and recombine to the raw root.

Only the bench's scenarios can show that the root is numerically correct. It sweeps all 256 operands against an independent integer search. The scenarios also show the exact latency per operand, and that a second start during an operation changes neither the result nor the timing.

// File: rtl/cube_root_unit.sv
module cube_root_unit #(
  parameter int OP_W   = 8,
  parameter int ROOT_W = 10,
  parameter int DIG_W  = 4,
  parameter int ITERS  = 11,
  parameter int SCALE  = 1000000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [OP_W-1:0]   operand,
  output logic              busy,
  output logic              done,
  output logic [ROOT_W-1:0] root,
  output logic [DIG_W-1:0]  dig_int,
  output logic [DIG_W-1:0]  dig_f1,
  output logic [DIG_W-1:0]  dig_f2
);
  localparam int RW     = 3 * ITERS + 1;
  localparam int SH_W   = $clog2(3 * ITERS);
  localparam int SH_TOP = 3 * (ITERS - 1);

  typedef enum logic [1:0] {S_IDLE, S_ROOT, S_HUND, S_TENS} state_t;

  state_t            st;
  logic [RW-1:0]     rem;
  logic [ROOT_W-1:0] y, q;
  logic [SH_W-1:0]   sh;
  logic [DIG_W-1:0]  h, t;

  logic [ROOT_W-1:0] y2, y_next;
  logic [RW-1:0]     yy, trial, sub;
  logic              fits;

  assign y2     = {y[ROOT_W-2:0], 1'b0};
  assign yy     = RW'(y2);
  assign trial  = RW'(3) * yy * (yy + RW'(1)) + RW'(1);
  assign sub    = trial << sh;
  assign fits   = (rem >> sh) >= trial;
  assign y_next = fits ? (y2 | ROOT_W'(1)) : y2;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; rem <= '0; y <= '0; q <= '0; sh <= '0; h <= '0; t <= '0;
      busy <= 1'b0; done <= 1'b0; root <= '0;
      dig_int <= '0; dig_f1 <= '0; dig_f2 <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          rem  <= RW'(operand) * RW'(SCALE);
          y    <= '0;
          sh   <= SH_W'(SH_TOP);
          busy <= 1'b1;
          st   <= S_ROOT;
        end
        S_ROOT: begin
          if (fits) rem <= rem - sub;
          y <= y_next;
          if (sh == '0) begin
            q <= y_next; h <= '0; t <= '0;
            st <= S_HUND;
          end else begin
            sh <= sh - SH_W'(3);
          end
        end
        S_HUND: begin
          if (q >= ROOT_W'(100)) begin
            q <= q - ROOT_W'(100);
            h <= h + DIG_W'(1);
          end else st <= S_TENS;
        end
        default: begin
          if (q >= ROOT_W'(10)) begin
            q <= q - ROOT_W'(10);
            t <= t + DIG_W'(1);
          end else begin
            root    <= y;
            dig_int <= h;
            dig_f1  <= t;
            dig_f2  <= q[DIG_W-1:0];
            done    <= 1'b1;
            busy    <= 1'b0;
            st      <= S_IDLE;
          end
        end
      endcase
    end
  end

  a_r5_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r5_busy_drop: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  a_r2_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> busy);
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable({root, dig_int, dig_f1, dig_f2}));
  a_r4_digit_range: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (dig_int <= 4'd6 && dig_f1 <= 4'd9 && dig_f2 <= 4'd9));
  a_r4_recombine: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (32'(root) == 32'(dig_int) * 100 + 32'(dig_f1) * 10 + 32'(dig_f2)));
  a_r3_root_max: assert property (@(posedge clk) disable iff (!rst_n)
    root <= ROOT_W'(634));
endmodule

// File: tb/sim_cube_root_unit.sv
module sim_cube_root_unit;
  logic       clk = 0, rst_n = 0, start = 0;
  logic [7:0] operand = 0;
  logic       busy, done;
  logic [9:0] root;
  logic [3:0] dig_int, dig_f1, dig_f2;
  int checks = 0, errors = 0, cycles = 0;

  always #5 clk = ~clk;

  cube_root_unit u0 (.clk(clk), .rst_n(rst_n), .start(start), .operand(operand),
    .busy(busy), .done(done), .root(root), .dig_int(dig_int), .dig_f1(dig_f1),
    .dig_f2(dig_f2));

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic longint ref_root(input longint n);
    longint y = 0;
    while ((y + 1) * (y + 1) * (y + 1) <= n * 1000000) y++;
    return y;
  endfunction

  task automatic run(input int n, input bit poke);
    longint e = ref_root(n);
    longint eh = e / 100, et = (e % 100) / 10, eu = e % 10;
    int k = 0;
    @(negedge clk); start = 1; operand = 8'(n);
    @(negedge clk); start = 0;
    check("R2 busy after start", busy, 1);
    while (k < 100) begin
      if (poke && k == 3) begin start = 1; operand = 8'(255 - n); end
      else start = 0;
      @(negedge clk); k++;
      if (done) break;
    end
    start = 0;
    check("R5 latency", k, 13 + eh + et);
    check("R3 root", root, e);
    check("R4 int digit", dig_int, eh);
    check("R4 frac digit 1", dig_f1, et);
    check("R4 frac digit 2", dig_f2, eu);
    check("R5 busy low with done", busy, 0);
    @(negedge clk);
    check("R5 done one cycle", done, 0);
    repeat (2) @(negedge clk);
    check("R7 root held", root, e);
    check("R7 digit held", {dig_int, dig_f1, dig_f2}, {eh[3:0], et[3:0], eu[3:0]});
    if (poke) check("R6 no restart", busy, 0);
  endtask

  task automatic finish_up;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d expected <150000 cycles", cycles);
      finish_up();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 busy reset", busy, 0);
    check("R1 done reset", done, 0);
    check("R1 root reset", root, 0);
    check("R1 digits reset", {dig_int, dig_f1, dig_f2}, 0);
    rst_n = 1;
    for (int n = 0; n < 256; n++) run(n, 0);
    run(255, 1);
    run(7, 1);
    run(0, 1);
    run(1, 1);
    finish_up();
  end
endmodule